// File: doc/BRIEF.md
# Posted-Write Buffer with Store-Barrier Drain

This block sits between a processor's store port and a memory or cache write interface. A store is taken into a small ordered queue in the cycle it is offered, so the processor moves on without waiting for memory. A drain engine sends the queued writes to memory oldest first, one at a time. Each write is a valid/ready request, and the queue slot is freed only when memory returns a write acknowledge for it.

Loads made by the same processor look the queue up on a combinational path. When the load address matches a queued store, the data of the youngest matching store is returned, so the processor always sees its own latest write. A store-barrier request holds the processor's store port closed until every store accepted before the barrier has been written and acknowledged. A store that follows the barrier therefore cannot overtake any store that came before it.

Top module: `store_buffer`

## Requirements
- R1: After reset, st_ready is 1 and mem_req_valid, bar_busy and ld_hit are 0.
- R2: A store offered while st_ready is 1 is taken at that clock edge. With DEPTH (default 8) stores held, st_ready is 0.
- R3: Queued stores go to memory strictly in arrival order, with address and data unchanged. At most one request is outstanding: after a request is accepted, mem_req_valid stays 0 until its mem_ack has been seen.
- R4: A queue slot is freed only by mem_ack. When the queue is full, st_ready returns to 1 in the cycle after the acknowledge of the oldest entry.
- R5: A bar_req seen while stores are queued raises bar_busy in the next cycle. While bar_busy is 1, st_ready is 0 and no store is taken.
- R6: bar_busy falls in the cycle after the acknowledge of the last queued store, and not earlier.
- R7: A bar_req seen while the queue is empty and no store is taken in that cycle completes at once: bar_busy stays 0.
- R8: A store and a bar_req in the same cycle are treated as store first, then barrier. The store is queued, and bar_busy stays 1 until that store is acknowledged.
- R9: ld_hit is 1 and ld_data equals the data of the youngest queued store whose address equals ld_addr. With no match, ld_hit is 0 and ld_data is 0.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid and its address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store |
| st_ready | output | 1 | Store is taken this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| bar_req | input | 1 | Store-barrier request |
| bar_busy | output | 1 | Barrier in progress; store port closed |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A queued store matches ld_addr |
| ld_data | output | DW | Data of the youngest match |
| mem_req_valid | output | 1 | Write request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Write address |
| mem_req_data | output | DW | Write data |
| mem_ack | input | 1 | Write acknowledge for the outstanding request |

## Verification
The bench fills the queue with stores that reuse the same addresses. A lookup that picks the oldest match instead of the youngest returns stale data, and a full queue that still asserts st_ready drops a store. During the drain, memory holds ready low and returns acknowledges after varying latencies. A design that frees a slot on the request handshake instead of the acknowledge, or that issues a second request early, shows up as a wrong order or as mem_req_valid high during an outstanding write. The barrier tests cover an empty queue, a barrier with a store in the same cycle, and a store held off during a barrier. These catch a bar_busy that falls one cycle early or late, and a store that slips past the barrier.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Position k steps after base on a ring of the given depth.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned depth);
    return (base + step) % depth;
  endfunction

  // Occupancy after one optional push and one optional pop.
  function automatic int unsigned occ_after(input int unsigned occ,
                                            input logic push,
                                            input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [PW-1:0] head,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [AW-1:0] ent_addr [DEPTH],
  output logic [DW-1:0] ent_data [DEPTH]
);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= PW'(ring_add(int'(tail_q), 1, DEPTH));
      if (pop)  head_q <= PW'(ring_add(int'(head_q), 1, DEPTH));
      count_q <= CW'(occ_after(int'(count_q), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_comb begin
    count     = count_q;
    full      = (count_q == CW'(DEPTH));
    head      = head_q;
    head_addr = addr_q[head_q];
    head_data = data_q[head_q];
    ent_addr  = addr_q;
    ent_data  = data_q;
  end

  // R2: never written past capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(DEPTH)));

  // R4: a slot can only be released when one is held
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));

endmodule

// File: rtl/sbuf_drain.sv
module sbuf_drain (
  input  logic clk,
  input  logic rst_n,
  input  logic have_entry,
  input  logic mem_ready,
  input  logic mem_ack,
  output logic mem_valid,
  output logic entry_done,
  output logic inflight
);

  logic inflight_q;
  logic issue;

  always_comb begin
    mem_valid  = have_entry && !inflight_q;
    issue      = mem_valid && mem_ready;
    entry_done = mem_ack && inflight_q;
    inflight   = inflight_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          inflight_q <= 1'b0;
    else if (issue)      inflight_q <= 1'b1;
    else if (entry_done) inflight_q <= 1'b0;
  end

  // R3: acknowledges only arrive for an outstanding write
  a_r3_ack_needs_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> inflight_q);

  // R3: after a handshake, no new request until the acknowledge
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R10: a stalled request stays valid
  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] ent_addr [DEPTH],
  input  logic [DW-1:0] ent_data [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] ld_addr,
  output logic          hit,
  output logic [DW-1:0] data
);

  // Scan oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PW-1:0] slot;
    hit  = 1'b0;
    data = '0;
    slot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = PW'(ring_add(int'(head), i, DEPTH));
      if ((i < int'(count)) && (ent_addr[slot] == ld_addr)) begin
        hit  = 1'b1;
        data = ent_data[slot];
      end
    end
  end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          bar_req,
  output logic          bar_busy,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_ack
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events
  logic          st_push;
  logic          entry_done;
  logic          ring_full;
  logic          inflight;
  logic [CW-1:0] occ;
  logic [CW-1:0] occ_next;
  logic [PW-1:0] head;
  logic          bar_q;
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];

  always_comb begin
    st_ready = !ring_full && !bar_q;
    st_push  = st_valid && st_ready;
    occ_next = CW'(occ_after(int'(occ), st_push, entry_done));
    bar_busy = bar_q;
  end

  sbuf_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (entry_done),
    .count     (occ),
    .full      (ring_full),
    .head      (head),
    .head_addr (mem_req_addr),
    .head_data (mem_req_data),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  sbuf_drain drain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .have_entry (occ != '0),
    .mem_ready  (mem_req_ready),
    .mem_ack    (mem_ack),
    .mem_valid  (mem_req_valid),
    .entry_done (entry_done),
    .inflight   (inflight)
  );

  sbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fwd_i (
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .head     (head),
    .count    (occ),
    .ld_addr  (ld_addr),
    .hit      (ld_hit),
    .data     (ld_data)
  );

  // Barrier: busy while anything accepted before it remains unacknowledged.
  // A store taken in the same cycle counts as earlier than the barrier.
  always_ff @(posedge clk) begin
    if (!rst_n) bar_q <= 1'b0;
    else        bar_q <= (bar_q || bar_req) && (occ_next != '0);
  end

  // R6: barrier only ends once the queue is empty
  a_r6_busy_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bar_busy) |-> (occ == '0));

  // R6: barrier ends right after an acknowledge
  a_r6_busy_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bar_busy) |-> $past(mem_ack));

  // R5: no store enters while a barrier is in progress
  a_r5_no_store_in_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    bar_busy |=> (occ <= $past(occ)));

  // R7: barrier on an empty queue completes immediately
  a_r7_empty_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req && !bar_busy && occ == '0 && !st_valid) |=> !bar_busy);

  // R8: store plus barrier together leaves the barrier pending
  a_r8_store_then_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    (st_push && bar_req) |=> bar_busy);

  // R4: occupancy drops only through an acknowledge
  a_r4_free_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < $past(occ)) |-> $past(mem_ack && inflight));

  // R10: a stalled request holds its payload
  a_r10_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> ($stable(mem_req_addr) && $stable(mem_req_data)));

endmodule

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        bar_req = 1'b0;
  logic        bar_busy;
  logic [31:0] ld_addr = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_data;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  store_buffer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_addr       (st_addr),
    .st_data       (st_data),
    .bar_req       (bar_req),
    .bar_busy      (bar_busy),
    .ld_addr       (ld_addr),
    .ld_hit        (ld_hit),
    .ld_data       (ld_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .mem_ack       (mem_ack)
  );

  // {store addr, store data, probe addr, expected probe data (0 = miss)}
  localparam logic [127:0] VEC [8] = '{
    {32'h100, 32'h11, 32'h100, 32'h11},
    {32'h104, 32'h22, 32'h108, 32'h00},
    {32'h100, 32'h33, 32'h100, 32'h33},
    {32'h108, 32'h44, 32'h104, 32'h22},
    {32'h104, 32'h55, 32'h104, 32'h55},
    {32'h10C, 32'h66, 32'h100, 32'h33},
    {32'h100, 32'h77, 32'h100, 32'h77},
    {32'h110, 32'h88, 32'h10C, 32'h66}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic push_store(input logic [31:0] a, input logic [31:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [31:0] exp);
    ld_addr = a;
    #1;
    chk({tag, " hit"}, {31'd0, ld_hit}, {31'd0, exp != 0});
    chk({tag, " data"}, ld_data, exp);
  endtask

  // Memory side for one write: stall, accept, wait lat cycles, acknowledge.
  task automatic drain_one(input logic [31:0] ea, input logic [31:0] ed,
                           input int lat, input bit busy_chk);
    while (!mem_req_valid) @(negedge clk);
    chk("R3 order addr", mem_req_addr, ea);
    chk("R3 order data", mem_req_data, ed);
    @(negedge clk);
    chk("R10 held valid", {31'd0, mem_req_valid}, 32'd1);
    chk("R10 held addr", mem_req_addr, ea);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3 one outstanding", {31'd0, mem_req_valid}, 32'd0);
    repeat (lat) @(negedge clk);
    if (busy_chk) chk("R6 busy before ack", {31'd0, bar_busy}, 32'd1);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 st_ready", {31'd0, st_ready}, 32'd1);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 bar_busy", {31'd0, bar_busy}, 32'd0);
    probe("R1 ld", 32'h100, 32'h0);

    // R2/R9 fill with repeated addresses, probing after each store
    for (int k = 0; k < 8; k++) begin
      chk("R2 ready before store", {31'd0, st_ready}, 32'd1);
      push_store(VEC[k][127:96], VEC[k][95:64]);
      probe("R9 youngest match", VEC[k][63:32], VEC[k][31:0]);
    end
    chk("R2 full stalls", {31'd0, st_ready}, 32'd0);
    probe("R9 newest entry", 32'h110, 32'h88);

    // R3/R4 drain in order with varying latency
    for (int k = 0; k < 8; k++) begin
      drain_one(VEC[k][127:96], VEC[k][95:64], k % 3, 1'b0);
      if (k == 0) begin
        chk("R4 slot freed after ack", {31'd0, st_ready}, 32'd1);
        probe("R9 after partial drain", 32'h100, 32'h77);
      end
    end
    @(negedge clk);
    chk("R3 idle after drain", {31'd0, mem_req_valid}, 32'd0);
    probe("R9 miss when empty", 32'h100, 32'h0);

    // R7 barrier on empty queue
    bar_req = 1'b1;
    @(negedge clk);
    bar_req = 1'b0;
    chk("R7 empty barrier busy", {31'd0, bar_busy}, 32'd0);
    chk("R7 empty barrier ready", {31'd0, st_ready}, 32'd1);

    // R5/R6 barrier with queued stores, a later store held off
    push_store(32'h200, 32'hA1);
    push_store(32'h204, 32'hB2);
    bar_req = 1'b1;
    @(negedge clk);
    bar_req = 1'b0;
    chk("R5 busy rises", {31'd0, bar_busy}, 32'd1);
    chk("R5 store port closed", {31'd0, st_ready}, 32'd0);
    st_valid = 1'b1; st_addr = 32'h208; st_data = 32'hC3;
    drain_one(32'h200, 32'hA1, 2, 1'b1);
    chk("R6 busy held mid-drain", {31'd0, bar_busy}, 32'd1);
    probe("R5 held store not queued", 32'h208, 32'h0);
    drain_one(32'h204, 32'hB2, 1, 1'b1);
    chk("R6 busy falls after last ack", {31'd0, bar_busy}, 32'd0);
    chk("R6 port reopens", {31'd0, st_ready}, 32'd1);
    @(negedge clk);
    st_valid = 1'b0;
    drain_one(32'h208, 32'hC3, 0, 1'b0);

    // R8 store and barrier in the same cycle
    st_valid = 1'b1; st_addr = 32'h300; st_data = 32'hD4; bar_req = 1'b1;
    @(negedge clk);
    st_valid = 1'b0; bar_req = 1'b0;
    chk("R8 barrier pending", {31'd0, bar_busy}, 32'd1);
    probe("R8 store queued", 32'h300, 32'hD4);
    drain_one(32'h300, 32'hD4, 1, 1'b1);
    chk("R8 barrier done", {31'd0, bar_busy}, 32'd0);

    repeat (2) @(negedge clk);
    report();
  end

endmodule